// File: doc/BRIEF.md
# Byte-Parity Bus to SECDED Storage Bridge

This block converts doublewords between a processor bus that protects each data byte with its own parity bit and a storage array that protects 64 data bits with an 8-bit single-error-correcting, double-error-detecting check code. On the store side the bus word is split into its data and parity. The data goes to storage with a freshly computed check code, and the bus parity is only checked. On the fetch side the 72-bit storage word is checked, a single flipped bit is repaired in the same pass, and byte parity is rebuilt from the repaired data before the word is returned in bus layout.

The store path is purely combinational. The fetch path has one register stage. A fetch strobe loads the repaired bus word, the raw syndrome and the two error flags together, and a valid output marks the cycle in which they are present. The code uses odd-weight columns. Every data bit maps to a distinct column of weight three or more, and every check bit maps to a unit column. Because of this, a syndrome with odd weight that matches a column points to one bit, and any other non-zero syndrome means an uncorrectable error.

Top module: `psb_bridge`

## Requirements
- R1: On a store, `st_mem_word[63:0]` holds the 64 data bits taken from the bus groups, where byte g sits at bus bits [9g+7:9g]. `st_mem_word[71:64]` holds the check code. The store path has no register.
- R2: The check code is linear in the data, and all-zero data gives a zero code. The code of a one-hot data word has odd weight of at least three, and the 64 one-hot codes are all distinct.
- R3: Bus parity is odd over each nine-bit group, and the parity bit sits at bus bit 9g+8. `st_par_err` is high when any group has an even count of ones. The check code is still computed from the data as received.
- R4: `fe_valid` is high exactly one cycle after a cycle with `fe_en` high. Under reset, `fe_valid`, `fe_ce` and `fe_ue` are low.
- R5: A fetch whose word is a valid code word returns its data with a zero syndrome and both flags low.
- R6: A fetch with one flipped data bit returns the corrected data with `fe_ce` high and `fe_ue` low. The syndrome equals the check code of a data word with only that bit set.
- R7: A fetch with one flipped check bit j returns the data unchanged with `fe_ce` high. The syndrome has only bit j set.
- R8: A fetch with two flipped bits raises `fe_ue` with `fe_ce` low. The data is returned as read, without correction. The syndrome is the XOR of the two single-bit syndromes, which is non-zero.
- R9: The fetched bus word puts data byte g at bits [9g+7:9g] and an odd parity bit at 9g+8. The parity is computed from the corrected data.
- R10: While `fe_valid` is low, both `fe_ce` and `fe_ue` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_bus_data | input | 72 | Store word in bus layout (byte then parity, eight groups) |
| st_mem_word | output | 72 | Store word in storage layout: check code above data |
| st_par_err | output | 1 | Bus parity mismatch on the store word |
| fe_en | input | 1 | Fetch strobe, storage word valid this cycle |
| fe_mem_word | input | 72 | Fetched storage word: check code above data |
| fe_valid | output | 1 | Registered fetch result present |
| fe_bus_data | output | 72 | Corrected fetch word in bus layout |
| fe_ce | output | 1 | Correctable single-bit error seen |
| fe_ue | output | 1 | Uncorrectable error seen |
| fe_syndrome | output | 8 | Raw syndrome of the fetched word |

## Verification
The hardest cases to reach from the ports are the exact syndromes for data-bit faults, because they depend on a code table the bench does not copy. The bench gets these codes from the block itself. It stores each one-hot data word and reads back the check code, then checks that the codes have odd weight, are distinct and are linear. It then uses them as the expected syndromes when it flips chosen bits of a stored word on the fetch port. Single-bit faults cover every data position and every check position. Double faults are drawn at random across all 72 bit positions.

// File: rtl/psb_pkg.sv
`timescale 1ns/1ps
package psb_pkg;
    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int MEM_W  = DATA_W + CHK_W;
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = 9;
    localparam int BUS_W  = LANES * LANE_W;
    localparam int IDX_W  = $clog2(DATA_W);

    typedef logic [CHK_W-1:0]  chk_t;
    typedef logic [DATA_W-1:0] dword_t;

    // Odd-weight columns, lightest first, never a unit vector.
    function automatic logic [DATA_W-1:0][CHK_W-1:0] build_cols();
        logic [DATA_W-1:0][CHK_W-1:0] tbl;
        int n;
        tbl = '0;
        n   = 0;
        for (int w = 3; w <= CHK_W; w += 2) begin
            for (int v = 1; v < (1 << CHK_W); v++) begin
                if ($countones(CHK_W'(v)) == w && n < DATA_W) begin
                    tbl[n[IDX_W-1:0]] = CHK_W'(v);
                    n++;
                end
            end
        end
        return tbl;
    endfunction

    localparam logic [DATA_W-1:0][CHK_W-1:0] H_COLS = build_cols();

    // Data bits that feed check bit j.
    function automatic dword_t row_mask(int j);
        dword_t m;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = H_COLS[i][j];
        end
        return m;
    endfunction
endpackage

// File: rtl/psb_encoder.sv
`timescale 1ns/1ps
module psb_encoder
    import psb_pkg::*;
(
    input  dword_t data,
    output chk_t   chk
);
    for (genvar j = 0; j < CHK_W; j++) begin : g_row
        localparam dword_t ROW = row_mask(j);
        assign chk[j] = ^(data & ROW);
    end
endmodule

// File: rtl/psb_decoder.sv
`timescale 1ns/1ps
module psb_decoder
    import psb_pkg::*;
(
    input  logic [MEM_W-1:0] word,
    output dword_t           data_fix,
    output chk_t             syn,
    output logic             ce,
    output logic             ue
);
    chk_t   recalc;
    dword_t hit;
    logic   syn_nz;
    logic   chk_hit;

    psb_encoder u_enc (
        .data (word[DATA_W-1:0]),
        .chk  (recalc)
    );

    assign syn = recalc ^ word[MEM_W-1:DATA_W];

    for (genvar i = 0; i < DATA_W; i++) begin : g_col
        assign hit[i] = (syn == H_COLS[i]);
    end

    assign syn_nz   = |syn;
    assign chk_hit  = syn_nz && $onehot(syn);
    assign data_fix = word[DATA_W-1:0] ^ hit;
    assign ce       = (|hit) || chk_hit;
    assign ue       = syn_nz && !ce;
endmodule

// File: rtl/psb_bus_unpack.sv
`timescale 1ns/1ps
module psb_bus_unpack
    import psb_pkg::*;
#(
    parameter bit ODD_PAR = 1'b1
) (
    input  logic [BUS_W-1:0] bus,
    output dword_t           data,
    output logic             par_err
);
    logic [LANES-1:0] lane_bad;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign data[8*g +: 8] = bus[LANE_W*g +: 8];
        assign lane_bad[g]    = (^bus[LANE_W*g +: LANE_W]) != ODD_PAR;
    end

    assign par_err = |lane_bad;
endmodule

// File: rtl/psb_bus_pack.sv
`timescale 1ns/1ps
module psb_bus_pack
    import psb_pkg::*;
#(
    parameter bit ODD_PAR = 1'b1
) (
    input  dword_t           data,
    output logic [BUS_W-1:0] bus
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bus[LANE_W*g +: 8]  = data[8*g +: 8];
        assign bus[LANE_W*g + 8]   = (^data[8*g +: 8]) ^ ODD_PAR;
    end
endmodule

// File: rtl/psb_bridge.sv
`timescale 1ns/1ps
module psb_bridge
    import psb_pkg::*;
#(
    parameter bit ODD_PAR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] st_bus_data,
    output logic [MEM_W-1:0] st_mem_word,
    output logic             st_par_err,
    input  logic             fe_en,
    input  logic [MEM_W-1:0] fe_mem_word,
    output logic             fe_valid,
    output logic [BUS_W-1:0] fe_bus_data,
    output logic             fe_ce,
    output logic             fe_ue,
    output logic [CHK_W-1:0] fe_syndrome
);
    // ---------------- store path ----------------
    dword_t st_data;
    chk_t   st_chk;

    psb_bus_unpack #(.ODD_PAR(ODD_PAR)) u_st_unpack (
        .bus     (st_bus_data),
        .data    (st_data),
        .par_err (st_par_err)
    );

    psb_encoder u_st_enc (
        .data (st_data),
        .chk  (st_chk)
    );

    assign st_mem_word = {st_chk, st_data};

    // ---------------- fetch path ----------------
    dword_t           fx_data;
    chk_t             fx_syn;
    logic             fx_ce;
    logic             fx_ue;
    logic [BUS_W-1:0] fx_bus;

    psb_decoder u_dec (
        .word     (fe_mem_word),
        .data_fix (fx_data),
        .syn      (fx_syn),
        .ce       (fx_ce),
        .ue       (fx_ue)
    );

    psb_bus_pack #(.ODD_PAR(ODD_PAR)) u_fe_pack (
        .data (fx_data),
        .bus  (fx_bus)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fe_valid    <= 1'b0;
            fe_ce       <= 1'b0;
            fe_ue       <= 1'b0;
            fe_syndrome <= '0;
            fe_bus_data <= '0;
        end else begin
            fe_valid <= fe_en;
            fe_ce    <= fe_en && fx_ce;
            fe_ue    <= fe_en && fx_ue;
            if (fe_en) begin
                fe_syndrome <= fx_syn;
                fe_bus_data <= fx_bus;
            end
        end
    end

    // ---------------- assertions ----------------
    logic [LANES-1:0] out_lane_ok;
    for (genvar g = 0; g < LANES; g++) begin : g_chk_lane
        assign out_lane_ok[g] = (^fe_bus_data[LANE_W*g +: LANE_W]) == ODD_PAR;
    end

    // R4
    fetch_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fe_en |=> fe_valid);
    // R4
    fetch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fe_en |=> !fe_valid);
    // R10
    flags_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fe_valid |-> (!fe_ce && !fe_ue));
    // R8
    no_dual_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fe_ce && fe_ue));
    // R6
    ce_odd_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fe_ce |-> (^fe_syndrome));
    // R8
    ue_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fe_ue |-> (fe_syndrome != '0));
    // R5
    clean_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_valid && fe_syndrome == '0) |-> (!fe_ce && !fe_ue));
    // R9
    out_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fe_valid |-> (&out_lane_ok));
endmodule

// File: tb/psb_bridge_bench.sv
`timescale 1ns/1ps
module psb_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [71:0] st_bus_data = '0;
    logic [71:0] st_mem_word;
    logic        st_par_err;
    logic        fe_en = 1'b0;
    logic [71:0] fe_mem_word = '0;
    logic        fe_valid;
    logic [71:0] fe_bus_data;
    logic        fe_ce;
    logic        fe_ue;
    logic [7:0]  fe_syndrome;

    always #10 clk = ~clk;

    psb_bridge u_psb_bridge (
        .clk(clk), .rst_n(rst_n),
        .st_bus_data(st_bus_data), .st_mem_word(st_mem_word), .st_par_err(st_par_err),
        .fe_en(fe_en), .fe_mem_word(fe_mem_word), .fe_valid(fe_valid),
        .fe_bus_data(fe_bus_data), .fe_ce(fe_ce), .fe_ue(fe_ue), .fe_syndrome(fe_syndrome)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [71:0] to_bus(input logic [63:0] d);
        logic [71:0] r;
        for (int g = 0; g < 8; g++) begin
            r[9*g +: 8] = d[8*g +: 8];
            r[9*g + 8]  = ~(^d[8*g +: 8]);
        end
        return r;
    endfunction

    logic [7:0] col [64];

    task automatic store(input logic [63:0] d, input int bad_lane, output logic [7:0] c);
        logic [71:0] b;
        b = to_bus(d);
        if (bad_lane >= 0) b[9*bad_lane + 8] = ~b[9*bad_lane + 8];
        st_bus_data = b;
        #2;
        check(st_mem_word[63:0] == d, "R1", "store data field", {8'h0, st_mem_word[63:0]}, {8'h0, d});
        check(st_par_err == (bad_lane >= 0), "R3", "store parity flag", {71'h0, st_par_err}, {71'h0, bad_lane >= 0});
        c = st_mem_word[71:64];
    endtask

    // Reference model state: the expectation for the word being driven now.
    logic [63:0] exp_data = '0;
    logic [7:0]  exp_syn  = '0;
    logic        exp_ce   = 1'b0;
    logic        exp_ue   = 1'b0;
    string       exp_tag  = "R5";

    task automatic fetch(input logic [63:0] d, input logic [7:0] c, input logic [71:0] flip);
        logic [7:0] s;
        int n;
        s = '0;
        n = $countones(flip);
        for (int i = 0; i < 64; i++) if (flip[i]) s ^= col[i];
        for (int j = 0; j < 8; j++) if (flip[64+j]) s[j] = ~s[j];
        @(posedge clk);
        #1;
        fe_en       = 1'b1;
        fe_mem_word = {c, d} ^ flip;
        exp_syn     = s;
        exp_ce      = (n == 1);
        exp_ue      = (n == 2);
        exp_data    = (n <= 1) ? d : d ^ flip[63:0];
        if (n == 0)               exp_tag = "R5";
        else if (n == 2)          exp_tag = "R8";
        else if (|flip[63:0])     exp_tag = "R6";
        else                      exp_tag = "R7";
    endtask

    task automatic idle(input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(posedge clk);
            #1;
            fe_en = 1'b0;
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    initial begin
        forever begin
            bit          m_en;
            logic [63:0] m_data;
            logic [7:0]  m_syn;
            logic        m_ce, m_ue;
            string       m_tag;
            @(posedge clk);
            m_en = fe_en && rst_n;
            m_data = exp_data; m_syn = exp_syn; m_ce = exp_ce; m_ue = exp_ue; m_tag = exp_tag;
            @(negedge clk);
            if (rst_n && !done) begin
                check(fe_valid == m_en, "R4", "valid timing", {71'h0, fe_valid}, {71'h0, m_en});
                if (m_en) begin
                    check(fe_bus_data == to_bus(m_data), m_tag, "bus data", fe_bus_data, to_bus(m_data));
                    check(fe_syndrome == m_syn, m_tag, "syndrome", {64'h0, fe_syndrome}, {64'h0, m_syn});
                    check(fe_ce == m_ce, m_tag, "ce flag", {71'h0, fe_ce}, {71'h0, m_ce});
                    check(fe_ue == m_ue, m_tag, "ue flag", {71'h0, fe_ue}, {71'h0, m_ue});
                    for (int g = 0; g < 8; g++)
                        check(^fe_bus_data[9*g +: 9] == 1'b1, "R9", "odd lane parity",
                              {63'h0, fe_bus_data[9*g +: 9]}, {63'h0, to_bus(m_data) >> (9*g)} & 72'h1FF);
                end else begin
                    check(!fe_ce && !fe_ue, "R10", "flags while idle", {70'h0, fe_ce, fe_ue}, 72'h0);
                end
            end
        end
    end

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  c, ca, cb, cab, c_ok;
        logic [63:0] a, b, d;
        logic [63:0] pats [4];
        bit          distinct;

        repeat (3) @(posedge clk);
        #5;
        check(fe_valid == 1'b0, "R4", "reset valid", {71'h0, fe_valid}, 72'h0);
        check(!fe_ce && !fe_ue, "R4", "reset flags", {70'h0, fe_ce, fe_ue}, 72'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Store side: code properties probed through the store port.
        store(64'h0, -1, c);
        check(c == 8'h0, "R2", "zero data code", {64'h0, c}, 72'h0);
        for (int i = 0; i < 64; i++) begin
            store(64'h1 << i, -1, col[i]);
            check(($countones(col[i]) >= 3) && (^col[i]), "R2", "column weight",
                  {64'h0, col[i]}, 72'h0);
        end
        distinct = 1'b1;
        for (int i = 0; i < 64; i++)
            for (int j = i + 1; j < 64; j++)
                if (col[i] == col[j]) distinct = 1'b0;
        check(distinct, "R2", "columns distinct", {71'h0, distinct}, 72'h1);
        for (int k = 0; k < 6; k++) begin
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            store(a, -1, ca);
            store(b, -1, cb);
            store(a ^ b, -1, cab);
            check(cab == (ca ^ cb), "R2", "linearity", {64'h0, cab}, {64'h0, ca ^ cb});
            check(st_mem_word[71:64] == cab, "R1", "check field", {64'h0, st_mem_word[71:64]}, {64'h0, cab});
        end
        d = 64'h0123_4567_89AB_CDEF;
        store(d, -1, c_ok);
        for (int g = 0; g < 8; g++) begin
            store(d, g, c);
            check(c == c_ok, "R3", "code despite parity error", {64'h0, c}, {64'h0, c_ok});
        end

        // Fetch side.
        pats[0] = 64'h0;
        pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[2] = 64'hA5A5_5A5A_C3C3_3C3C;
        pats[3] = {$urandom, $urandom};
        for (int p = 0; p < 4; p++) begin
            store(pats[p], -1, c);
            fetch(pats[p], c, 72'h0);
            for (int i = 0; i < 64; i += (p == 1) ? 1 : 7)
                fetch(pats[p], c, 72'h1 << i);
            for (int j = 0; j < 8; j++)
                fetch(pats[p], c, 72'h1 << (64 + j));
            for (int k = 0; k < 12; k++) begin
                int x, y;
                x = $urandom_range(0, 71);
                y = $urandom_range(0, 71);
                while (y == x) y = $urandom_range(0, 71);
                fetch(pats[p], c, (72'h1 << x) | (72'h1 << y));
            end
            fetch(pats[p], c, (72'h1 << 5) | (72'h1 << 70));
            idle(2);
        end
        // Back-to-back mixed fetches.
        store(pats[2], -1, c);
        fetch(pats[2], c, 72'h0);
        fetch(pats[2], c, 72'h1 << 33);
        fetch(pats[2], c, 72'h3);
        fetch(pats[2], c, 72'h1 << 71);
        idle(4);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule